// File: doc/BRIEF.md
# CPU Wait-State Clock Gate

This block parks the processor core in a low-power wait state on request and brings it back when a peripheral needs service. A single-cycle strobe from the core starts the wait. From the next cycle on, the core clock enable is held low and the peripheral clock enable stays high, so timers, serial ports and other modules keep running and can still raise interrupts. On the first wait cycle the block also sends a one-cycle pulse that clears the interrupt mask bit in the condition code register. This lets the core accept the interrupt that wakes it.

Each interrupt line has a request bit and an enable bit. The wake condition is true when any line has both bits set. When the wake condition is seen during a wait cycle, the next cycle restores the core clock enable, drops the wait indicator and raises a one-cycle pulse that starts interrupt stacking. A requested line that is not enabled never ends the wait. The reset input is asynchronous and active low. Its release is synchronised inside the block, and both clock enables are high while reset is asserted.

Top module: `cpu_wait_gate`

## Requirements
- R1: While reset is asserted, and for a short time after it is released, `in_wait`, `mask_clr` and `stack_start` are 0 and `cpu_clk_en` and `per_clk_en` are 1. Asserting reset during a wait returns these outputs to the same values at once, without waiting for a clock edge.
- R2: If `wait_stb` is 1 at a clock edge while the block is running, then after that edge `in_wait` is 1 and `cpu_clk_en` is 0.
- R3: `per_clk_en` is 1 in every cycle, whether the block is running or waiting.
- R4: `mask_clr` is 1 for exactly the first cycle of each wait and is 0 in every other cycle.
- R5: The wake condition is the OR over every line i of (`irq_req[i]` AND `irq_en[i]`). If it is 1 at an edge during a wait, then after that edge `in_wait` is 0, `cpu_clk_en` is 1 and `stack_start` is 1. `stack_start` returns to 0 one cycle later.
- R6: During a wait, requests whose enable bit is 0 are ignored. While the wake condition is 0, `in_wait` stays 1, `cpu_clk_en` stays 0 and `stack_start` stays 0.
- R7: A `wait_stb` pulse that arrives during a wait is ignored. The block stays in the wait and does not issue another `mask_clr` pulse.
- R8: If the wake condition is already 1 when the wait starts, the wait lasts exactly one cycle. `mask_clr` is 1 in that cycle and `stack_start` is 1 in the cycle after it.
- R9: `cpu_clk_en` always equals the inverse of `in_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| wait_stb | input | 1 | One-cycle request from the core to enter the wait state |
| irq_req | input | N_IRQ | Interrupt request, one bit per peripheral line |
| irq_en | input | N_IRQ | Interrupt enable, one bit per peripheral line |
| cpu_clk_en | output | 1 | Clock enable for the core |
| per_clk_en | output | 1 | Clock enable for the peripherals |
| mask_clr | output | 1 | One-cycle pulse that clears the interrupt mask bit |
| stack_start | output | 1 | One-cycle pulse that starts interrupt stacking |
| in_wait | output | 1 | High while the core is in the wait state |

## Verification
The properties are disabled only while the raw `rst_n` input is low. They therefore assume that `wait_stb` stays low during the few cycles in which the internal synchroniser still holds the block in reset after `rst_n` rises. The bench waits several cycles after each release before driving anything. The wake properties also assume that the request and enable inputs change only between clock edges. The bench changes them only at falling edges, and it clears them after every wake so that each wait starts from a known condition.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
  typedef enum logic [0:0] {
    WG_RUN  = 1'b0,
    WG_IDLE = 1'b1
  } wg_state_e;
endpackage

// File: rtl/wgc_rst_sync.sv
// Asserts reset at once and releases it after STAGES clock edges.
module wgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wgc_wake_detect.sv
// Combines the request and enable bits of every interrupt line into one wake flag.
module wgc_wake_detect #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             wake
);
  logic [N_IRQ-1:0] line_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_req[i] & irq_en[i];
  end

  assign wake = |line_hit;
endmodule

// File: rtl/wgc_fsm.sv
// Two-state controller; produces one-cycle entry and exit events.
module wgc_fsm
  import wgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_stb,
  input  logic wake,
  output logic enter,
  output logic leave
);
  wg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    enter   = 1'b0;
    leave   = 1'b0;
    unique case (state_q)
      WG_RUN: begin
        if (wait_stb) begin
          state_d = WG_IDLE;
          enter   = 1'b1;
        end
      end
      WG_IDLE: begin
        if (wake) begin
          state_d = WG_RUN;
          leave   = 1'b1;
        end
      end
      default: state_d = WG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WG_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wgc_outputs.sv
// Output registers: clock enables, pulses and the wait indicator.
module wgc_outputs (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic mask_clr,
  output logic stack_start,
  output logic in_wait
);
  logic cpu_en_d, per_en_d, mask_d, stack_d, wait_d;

  always_comb begin
    cpu_en_d = cpu_clk_en;
    wait_d   = in_wait;
    if (enter) begin
      cpu_en_d = 1'b0;
      wait_d   = 1'b1;
    end
    if (leave) begin
      cpu_en_d = 1'b1;
      wait_d   = 1'b0;
    end
    per_en_d = 1'b1;
    mask_d   = enter;
    stack_d  = leave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en  <= 1'b1;
      per_clk_en  <= 1'b1;
      mask_clr    <= 1'b0;
      stack_start <= 1'b0;
      in_wait     <= 1'b0;
    end else begin
      cpu_clk_en  <= cpu_en_d;
      per_clk_en  <= per_en_d;
      mask_clr    <= mask_d;
      stack_start <= stack_d;
      in_wait     <= wait_d;
    end
  end
endmodule

// File: rtl/cpu_wait_gate.sv
module cpu_wait_gate #(
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_stb,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             mask_clr,
  output logic             stack_start,
  output logic             in_wait
);
  logic rst_int_n, wake, enter, leave;

  wgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  wgc_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en), .wake(wake)
  );

  wgc_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .wait_stb(wait_stb), .wake(wake),
    .enter(enter), .leave(leave)
  );

  wgc_outputs u_out (
    .clk(clk), .rst_n(rst_int_n), .enter(enter), .leave(leave),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mask_clr(mask_clr),
    .stack_start(stack_start), .in_wait(in_wait)
  );
endmodule

// File: rtl/wgc_checker.sv
module wgc_checker #(
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_stb,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             mask_clr,
  input logic             stack_start,
  input logic             in_wait
);
  logic wake_ref;
  assign wake_ref = |(irq_req & irq_en);

  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wait && wait_stb) |=> (in_wait && !cpu_clk_en));

  a_r3_per_on: assert property (@(posedge clk) disable iff (!rst_n)
    per_clk_en);

  a_r4_mask_first: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr |-> (in_wait && !$past(in_wait)));

  a_r4_mask_once: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr |=> !mask_clr);

  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && wake_ref) |=> (!in_wait && cpu_clk_en && stack_start));

  a_r5_stack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stack_start |=> !stack_start);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !wake_ref) |=> (in_wait && !stack_start));

  a_r9_cpu_en: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en != in_wait);
endmodule

bind cpu_wait_gate wgc_checker #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .irq_req(irq_req),
  .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .mask_clr(mask_clr), .stack_start(stack_start), .in_wait(in_wait)
);

// File: tb/sim_cpu_wait_gate.sv
module sim_cpu_wait_gate;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_stb = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] en = '0;
  logic cpu_clk_en, per_clk_en, mask_clr, stack_start, in_wait;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_wait_gate #(.N_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .irq_req(req), .irq_en(en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mask_clr(mask_clr),
    .stack_start(stack_start), .in_wait(in_wait)
  );

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk_idle_outputs(input string tag);
    chk(tag, "in_wait", in_wait, 1'b0);
    chk(tag, "cpu_clk_en", cpu_clk_en, 1'b1);
    chk(tag, "per_clk_en", per_clk_en, 1'b1);
    chk(tag, "mask_clr", mask_clr, 1'b0);
    chk(tag, "stack_start", stack_start, 1'b0);
  endtask

  task automatic wake_out;
    req = 1; en = 1;
    tick;
    chk("R5", "stack_start", stack_start, 1'b1);
    req = '0; en = '0;
    tick;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs while reset is held
    repeat (3) tick;
    chk_idle_outputs("R1");
    rst_n = 1'b1;
    repeat (4) tick;
    chk_idle_outputs("R1");

    // R2..R6, R9: every request/enable pattern seen in the first wait cycle
    for (int r = 0; r < (1 << N); r++) begin
      for (int e = 0; e < (1 << N); e++) begin
        logic w;
        w = |(r[N-1:0] & e[N-1:0]);
        wait_stb = 1'b1;
        tick;
        wait_stb = 1'b0;
        chk("R2", "in_wait", in_wait, 1'b1);
        chk("R2", "cpu_clk_en", cpu_clk_en, 1'b0);
        chk("R4", "mask_clr", mask_clr, 1'b1);
        chk("R3", "per_clk_en", per_clk_en, 1'b1);
        req = r[N-1:0]; en = e[N-1:0];
        tick;
        chk(w ? "R5" : "R6", "in_wait", in_wait, !w);
        chk(w ? "R5" : "R6", "stack_start", stack_start, w);
        chk("R9", "cpu_clk_en", cpu_clk_en, !in_wait);
        chk("R4", "mask_clr", mask_clr, 1'b0);
        chk("R3", "per_clk_en", per_clk_en, 1'b1);
        req = '0; en = '0;
        if (!w) wake_out;
        else tick;
        chk("R5", "stack_start", stack_start, 1'b0);
        chk("R5", "cpu_clk_en", cpu_clk_en, 1'b1);
      end
    end

    // R7: a second strobe during the wait is ignored
    wait_stb = 1'b1;
    tick;
    tick;
    wait_stb = 1'b0;
    chk("R7", "in_wait", in_wait, 1'b1);
    chk("R7", "mask_clr", mask_clr, 1'b0);
    wake_out;

    // R8: wake already present at entry
    wait_stb = 1'b1; req = 4'b0100; en = 4'b0110;
    tick;
    wait_stb = 1'b0;
    chk("R8", "in_wait", in_wait, 1'b1);
    chk("R8", "mask_clr", mask_clr, 1'b1);
    tick;
    chk("R8", "in_wait", in_wait, 1'b0);
    chk("R8", "stack_start", stack_start, 1'b1);
    req = '0; en = '0;
    tick;

    // R1: asynchronous reset during a wait
    wait_stb = 1'b1;
    tick;
    wait_stb = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk_idle_outputs("R1");
    tick;
    rst_n = 1'b1;
    repeat (4) tick;
    chk_idle_outputs("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule